// File: doc/BRIEF.md
# Edge Detection Interrupt Controller

This block watches a word of digital input channels and reports level transitions on the channels that the host has armed. Each channel can be armed separately for low-to-high and for high-to-low transitions. A global switch for each direction sits on top of the per-channel arming. A qualifying transition sets a sticky edge flag. A second transition that arrives while that flag is still set also sets a sticky overflow flag. Either flag can raise the single interrupt line, under separate enables and a master output enable.

The host reaches the block through a byte-wide register port. Writes take effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. Software normally clears both flags through the write-one-to-clear command byte and then writes the control byte. Writing zero to the control byte silences the interrupt line and leaves the flags as they are.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every arming byte, the control byte and the status byte read 0, and `irq` is low.
- R2: Channel 8k+j is armed for rising transitions by bit j of the byte at address 0x0+k, and rising transitions are enabled globally by control bit 3 (control at 0x8). If `din` changes from 0 to 1 on an armed channel, status bit 0 (status at 0x9) reads 1 from the next clock on.
- R3: Channel 8k+j is armed for falling transitions by bit j of the byte at address 0x4+k, and falling transitions are enabled globally by control bit 4. A 1-to-0 change on an armed channel sets status bit 0 on the next clock.
- R4: A transition has no effect on status if its channel is not armed for that direction, or if the matching global direction bit is clear.
- R5: A qualifying transition that occurs while status bit 0 is set sets status bit 1 (overflow). Overflow then stays set until it is cleared.
- R6: A write to the command byte at 0xA clears status bit 0 when data bit 3 is 1, and clears status bit 1 when data bit 2 is 1. Zero bits leave the flags unchanged. The command byte reads 0.
- R7: If a qualifying transition and a clear of the same flag fall in the same cycle, the flag ends set.
- R8: Status bit 2 and `irq` both equal control bit 2 AND ((edge flag AND control bit 0) OR (overflow flag AND control bit 1)).
- R9: With control written to 0, `irq` stays low and the edge and overflow flags are retained.
- R10: Every arming byte and the control byte (bits 4:0) read back the value written. Writes to the status address change nothing.
- R11: An input held at a constant level causes no further events after its transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| din | input | 8*NBYTES | Input channel word |
| irq | output | 1 | Interrupt line |

## Verification
The hardest case to reach from the ports is a transition and a write-one-to-clear landing on the same clock edge. This must be tried both with the edge flag already set and with it clear, so that the set-wins rule and the overflow rule are checked together. The bench drives the input change and the command write at the same negedge, so the design samples both at one posedge. The interrupt equation is swept over all 32 control values for each of the four flag combinations. Each combination is built first by transitions and selective clears.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_RISE = 4'h0;
  localparam logic [ADDR_W-1:0] A_FALL = 4'h4;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h8;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h9;
  localparam logic [ADDR_W-1:0] A_CLR  = 4'hA;

  localparam int KB_EDGE = 3;
  localparam int KB_OVF  = 2;

  // control byte, bit 4 down to bit 0
  typedef struct packed {
    logic fall_on;
    logic rise_on;
    logic irq_on;
    logic ovf_ie;
    logic edge_ie;
  } ctrl_t;

  function automatic logic pend_calc(ctrl_t c, logic e, logic o);
    return c.irq_on & ((e & c.edge_ie) | (o & c.ovf_ie));
  endfunction
endpackage

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int NBYTES = 3,
  localparam int NCH = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [7:0]        stat_byte,
  output logic [7:0]        rdata,
  output logic [NCH-1:0]    rise_en,
  output logic [NCH-1:0]    fall_en,
  output ctrl_t             ctrl,
  output logic              clr_edge,
  output logic              clr_ovf
);
  logic [NCH-1:0] rise_q, fall_q;
  ctrl_t          ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      ctrl_q <= '0;
    end else if (we) begin
      for (int k = 0; k < NBYTES; k++) begin
        if (addr == A_RISE + ADDR_W'(k)) rise_q[k*8 +: 8] <= wdata;
        if (addr == A_FALL + ADDR_W'(k)) fall_q[k*8 +: 8] <= wdata;
      end
      if (addr == A_CTRL) ctrl_q <= ctrl_t'(wdata[4:0]);
    end
  end

  assign clr_edge = we && (addr == A_CLR) && wdata[KB_EDGE];
  assign clr_ovf  = we && (addr == A_CLR) && wdata[KB_OVF];

  always_comb begin
    rdata = 8'h00;
    for (int k = 0; k < NBYTES; k++) begin
      if (addr == A_RISE + ADDR_W'(k)) rdata = rise_q[k*8 +: 8];
      if (addr == A_FALL + ADDR_W'(k)) rdata = fall_q[k*8 +: 8];
    end
    if (addr == A_CTRL) rdata = {3'b000, ctrl_q};
    if (addr == A_STAT) rdata = stat_byte;
  end

  assign rise_en = rise_q;
  assign fall_en = fall_q;
  assign ctrl    = ctrl_q;
endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
  parameter int NCH = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] din,
  input  logic [NCH-1:0] rise_en,
  input  logic [NCH-1:0] fall_en,
  input  logic           rise_on,
  input  logic           fall_on,
  output logic           any_edge
);
  logic [NCH-1:0] prev_q;
  logic [NCH-1:0] hit;

  // on reset the history tracks the input, so release gives no false edge
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= din;
    else        prev_q <= din;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic up, down;
    assign up     = din[i] & ~prev_q[i];
    assign down   = ~din[i] & prev_q[i];
    assign hit[i] = (up & rise_en[i] & rise_on) | (down & fall_en[i] & fall_on);
  end

  assign any_edge = |hit;

  p_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(din) == din) |-> !any_edge);
endmodule

// File: rtl/edge_irq_status.sv
module edge_irq_status
  import edge_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  any_edge,
  input  logic  clr_edge,
  input  logic  clr_ovf,
  input  ctrl_t ctrl,
  output logic  edge_st,
  output logic  ovf_st,
  output logic  pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_st <= 1'b0;
      ovf_st  <= 1'b0;
    end else begin
      if (any_edge)      edge_st <= 1'b1;
      else if (clr_edge) edge_st <= 1'b0;
      if (any_edge && edge_st) ovf_st <= 1'b1;
      else if (clr_ovf)        ovf_st <= 1'b0;
    end
  end

  assign pend = pend_calc(ctrl, edge_st, ovf_st);

  p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_edge |=> edge_st);
  p_edge_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edge && !any_edge) |=> !edge_st);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && any_edge && edge_st) |=> ovf_st);
  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_edge && edge_st) |=> ovf_st);
  p_ovf_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_st && !clr_ovf) |=> ovf_st);
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int NBYTES = 3,
  localparam int NCH = 8 * NBYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [3:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [NCH-1:0]   din,
  output logic             irq
);
  logic [NCH-1:0] rise_en, fall_en;
  ctrl_t          ctrl;
  logic           clr_edge, clr_ovf, any_edge;
  logic           edge_st, ovf_st, pend;
  logic [7:0]     stat_byte;

  assign stat_byte = {5'b00000, pend, ovf_st, edge_st};

  edge_irq_regs #(.NBYTES(NBYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .stat_byte(stat_byte), .rdata(bus_rdata), .rise_en(rise_en),
    .fall_en(fall_en), .ctrl(ctrl), .clr_edge(clr_edge), .clr_ovf(clr_ovf)
  );

  edge_irq_detect #(.NCH(NCH)) u_detect (
    .clk(clk), .rst_n(rst_n), .din(din), .rise_en(rise_en), .fall_en(fall_en),
    .rise_on(ctrl.rise_on), .fall_on(ctrl.fall_on), .any_edge(any_edge)
  );

  edge_irq_status u_status (
    .clk(clk), .rst_n(rst_n), .any_edge(any_edge), .clr_edge(clr_edge),
    .clr_ovf(clr_ovf), .ctrl(ctrl), .edge_st(edge_st), .ovf_st(ovf_st),
    .pend(pend)
  );

  assign irq = pend;

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.irq_on |-> !irq);
  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (edge_st || ovf_st));
endmodule

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;
  localparam int NB  = 3;
  localparam int NCH = 8 * NB;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_we = 1'b0;
  logic [3:0]     bus_addr = '0;
  logic [7:0]     bus_wdata = '0;
  logic [7:0]     bus_rdata;
  logic [NCH-1:0] din = '0;
  logic           irq;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edge_irq_ctrl #(.NBYTES(NB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din(din), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic drive(input logic [NCH-1:0] v);
    @(negedge clk);
    din = v;
    @(negedge clk);
  endtask

  task automatic stat_is(input string req, input logic [7:0] exp);
    logic [7:0] d;
    rd(4'h9, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), d);
      chk("R1", d, 0);
    end
    chk("R1 irq", irq, 0);

    // R10: readback of the register map
    for (int k = 0; k < NB; k++) begin
      wr(4'(k), 8'hA5 + 8'(k));
      wr(4'(4 + k), 8'h3C ^ 8'(k));
    end
    wr(4'h8, 8'hFF);
    wr(4'h9, 8'hFF);
    for (int k = 0; k < NB; k++) begin
      rd(4'(k), d);     chk("R10 rise", d, 8'hA5 + 8'(k));
      rd(4'(4 + k), d); chk("R10 fall", d, 8'h3C ^ 8'(k));
    end
    rd(4'h8, d); chk("R10 ctrl", d, 8'h1F);
    rd(4'h9, d); chk("R10 stat", d, 8'h00);
    rd(4'hA, d); chk("R6 cmd reads 0", d, 8'h00);
    for (int k = 0; k < NB; k++) begin
      wr(4'(k), 8'h00);
      wr(4'(4 + k), 8'h00);
    end
    wr(4'h8, 8'h18);

    // R2/R3/R4: per-channel sweep, both directions
    for (int ch = 0; ch < NCH; ch++) begin
      for (int dir = 0; dir < 2; dir++) begin
        logic [3:0] ea;
        int nb;
        ea = dir == 0 ? 4'(ch / 8) : 4'(4 + ch / 8);
        nb = (ch + 1) % NCH;
        wr(ea, 8'(1 << (ch % 8)));
        wr(4'hA, 8'h0C);
        drive(NCH'(1) << nb);
        stat_is("R4 other channel up", 8'h00);
        drive('0);
        stat_is("R4 other channel down", 8'h00);
        drive(NCH'(1) << ch);
        stat_is(dir == 0 ? "R2 rise" : "R4 rise unarmed", dir == 0 ? 8'h01 : 8'h00);
        wr(4'hA, 8'h0C);
        drive('0);
        stat_is(dir == 1 ? "R3 fall" : "R4 fall unarmed", dir == 1 ? 8'h01 : 8'h00);
        wr(4'hA, 8'h0C);
        wr(ea, 8'h00);
      end
    end

    // R4 global gate and R11 steady level
    for (int k = 0; k < NB; k++) wr(4'(k), 8'hFF);
    wr(4'h8, 8'h10);
    drive('1);
    stat_is("R4 global rise off", 8'h00);
    wr(4'h8, 8'h18);
    repeat (3) @(negedge clk);
    stat_is("R11 steady high", 8'h00);
    drive('0);
    stat_is("R4 fall unarmed", 8'h00);
    drive('1);
    stat_is("R2 after re-enable", 8'h01);

    // R5/R6: overflow and selective clears
    wr(4'hA, 8'h08);
    stat_is("R6 edge clear", 8'h00);
    drive('0);
    drive('1);
    stat_is("R2", 8'h01);
    drive('0);
    drive('1);
    stat_is("R5 overflow", 8'h03);
    wr(4'hA, 8'h00);
    stat_is("R6 zero write", 8'h03);
    wr(4'hA, 8'h04);
    stat_is("R6 ovf clear", 8'h01);
    wr(4'hA, 8'h08);
    stat_is("R6 edge clear", 8'h00);

    // R7: transition and clear in the same cycle
    drive('0);
    @(negedge clk);
    din = '1; bus_addr = 4'hA; bus_wdata = 8'h0C; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    stat_is("R7 edge clear flag", 8'h01);
    drive('0);
    @(negedge clk);
    din = '1; bus_addr = 4'hA; bus_wdata = 8'h0C; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    stat_is("R7 edge set flag", 8'h03);

    // R8/R9: all control values against all flag combinations
    for (int s = 0; s < 4; s++) begin
      logic e, o;
      e = s[0]; o = s[1];
      wr(4'h8, 8'h18);
      drive('0);
      wr(4'hA, 8'h0C);
      if (o) begin
        drive('1); drive('0); drive('1); drive('0);
        wr(4'hA, 8'h08);
      end
      if (e) begin
        drive('1); drive('0);
      end
      for (int c = 0; c < 32; c++) begin
        logic p;
        p = c[2] & ((e & c[0]) | (o & c[1]));
        wr(4'h8, 8'(c));
        rd(4'h9, d);
        chk(c == 0 ? "R9 status" : "R8 status", d, {5'b0, p, o, e});
        chk(c == 0 ? "R9 irq" : "R8 irq", irq, p);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule